// File: doc/BRIEF.md
# Base-16 Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point numbers whose exponent counts powers of sixteen. A start strobe captures both operands together with an operation select, a precision select and a rounding enable. The block sequences through these steps:

- Order the operands by magnitude.
- Align the smaller one by whole hex digits.
- Add or subtract the fractions.
- Renormalize one hex digit per cycle.
- Round if enabled.
- Pack the result, saturating on exponent overflow and flushing to zero on underflow.

A one-cycle done pulse marks the moment the packed words and condition flags become valid. They then hold until the next operation completes.

Each operand is a 32-bit high word with a 32-bit low extension word. In wide mode the extension takes part in the arithmetic, which covers both double precision and a guard-extended single precision. In narrow mode only the 24-bit high fraction is used, and every low bit is discarded. Operands are supplied normalized: the leading hex digit is nonzero, or the whole fraction is zero.

Top module: `hfa_addsub`

## Requirements
- R1: Word layout: bit 31 is the sign (1 = negative), bits 30:24 hold an excess-64 exponent and bits 23:0 hold the high fraction. With `sub` high, the sign of operand B is inverted before any other step.
- R2: If operand A's fraction is zero, the result is operand B (with its sign possibly inverted by R1). Otherwise, if B's fraction is zero, the result is A unchanged.
- R3: The operand of larger magnitude is the reference. Magnitude is ordered by exponent, then high fraction, then low fraction. The result sign is the sign of that larger operand.
- R4: The smaller operand is shifted right by four bits per unit of exponent difference. In wide mode the shift runs across the 56-bit combined fraction, and a difference of 14 or more removes it. In narrow mode `a_lo` and `b_lo` are ignored, the shift uses only the 24-bit fraction, a difference of 6 or more removes it, and `res_lo` is zero.
- R5: When the signs differ, the fractions are subtracted. A nonzero result is shifted left one hex digit at a time, decrementing the exponent, until its leading digit is nonzero.
- R6: When the signs agree and the fraction sum carries out of bit 24 of the high fraction, the sum shifts right one hex digit and the exponent rises by one.
- R7: With `rnd_en` high and bit 31 of the low fraction set, one is added to the high fraction. If that carries out of bit 24, the high fraction shifts right one digit and the exponent rises by one. The low word is unchanged.
- R8: A zero fraction gives `res_hi` = 0 and `res_lo` = 0 with all three flags clear.
- R9: An exponent below zero gives a clean zero with only `cc_v` set.
- R10: An exponent above 127 gives exponent and fraction all ones with the sign kept and `res_lo` all ones. It sets `cc_v` together with `cc_l` (negative) or `cc_g` (positive).
- R11: An in-range nonzero result sets `cc_l` when negative and `cc_g` when positive, with `cc_v` clear.
- R12: After reset all outputs are zero. `start` is accepted only when idle, and a start pulse during an operation is ignored. `done` is high for exactly one cycle per accepted start. The outputs hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Capture operands and begin an operation (when idle) |
| sub | input | 1 | 1 = subtract B from A, 0 = add |
| wide | input | 1 | 1 = use the 56-bit fraction, 0 = 24-bit fraction only |
| rnd_en | input | 1 | Enable rounding on bit 31 of the low fraction |
| a_hi | input | 32 | Operand A sign, exponent and high fraction |
| a_lo | input | 32 | Operand A low fraction extension |
| b_hi | input | 32 | Operand B sign, exponent and high fraction |
| b_lo | input | 32 | Operand B low fraction extension |
| res_hi | output | 32 | Result sign, exponent and high fraction |
| res_lo | output | 32 | Result low fraction word |
| cc_v | output | 1 | Exponent overflow or underflow flag |
| cc_g | output | 1 | Result is greater than zero |
| cc_l | output | 1 | Result is less than zero |
| done | output | 1 | One-cycle pulse: result outputs are valid |

## Verification
Rounding and exponent saturation can land in the same final cycle. A round-up can carry a full fraction out of the top digit, and at exponent 127 that carry pushes the result into overflow. A directed case provokes this: an all-ones fraction at the top exponent, with the low guard bit set, is added to a zero. The case passes only if the saturated pattern with the positive flag appears, not a wrapped exponent. The carry renormalization of an effective add also shares a cycle with overflow. Two maximal positive operands and two maximal negative operands probe this, and each must saturate with the matching sign flag.

// File: rtl/hfa_pkg.sv
package hfa_pkg;
  parameter int HI_W  = 24;
  parameter int LO_W  = 32;
  parameter int EXP_W = 7;
  parameter int DIG_W = 4;

  localparam int FR_W       = HI_W + LO_W;
  localparam int WORD_W     = 1 + EXP_W + HI_W;
  localparam int SE_W       = EXP_W + 3;
  localparam int WIDE_CUT   = FR_W / DIG_W;
  localparam int NARROW_CUT = HI_W / DIG_W;
  localparam int EXP_MAX    = (1 << EXP_W) - 1;
  localparam int CNT_W      = $clog2(WIDE_CUT + 2) + 1;

  // ex holds a two's complement exponent, compared through $signed
  typedef struct packed {
    logic            sgn;
    logic [SE_W-1:0] ex;
    logic [FR_W-1:0] fr;
  } ufp_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ALIGN, ST_NORM, ST_FIN} hfa_st_t;
endpackage

// File: rtl/hfa_align.sv
module hfa_align
  import hfa_pkg::*;
(
  input  ufp_t x_i,
  input  ufp_t y_i,
  input  logic wide_i,
  output ufp_t sum_o
);
  localparam logic [FR_W-1:0] HI_ONLY = {{HI_W{1'b1}}, {LO_W{1'b0}}};

  logic            x_zero, y_zero, swap;
  ufp_t            big, sml;
  logic [SE_W-1:0] ediff, cut;
  logic [FR_W-1:0] keep_mask, al;
  logic [FR_W:0]   raw;

  always_comb begin
    x_zero    = (x_i.fr == '0);
    y_zero    = (y_i.fr == '0);
    swap      = ($signed(x_i.ex) < $signed(y_i.ex)) ||
                ((x_i.ex == y_i.ex) && (x_i.fr < y_i.fr));
    big       = swap ? y_i : x_i;
    sml       = swap ? x_i : y_i;
    ediff     = big.ex - sml.ex;
    cut       = wide_i ? SE_W'(WIDE_CUT) : SE_W'(NARROW_CUT);
    keep_mask = wide_i ? {FR_W{1'b1}} : HI_ONLY;
    if (ediff >= cut) al = '0;
    else              al = (sml.fr >> (ediff * SE_W'(DIG_W))) & keep_mask;
    if (big.sgn != sml.sgn) raw = {1'b0, big.fr} - {1'b0, al};
    else                    raw = {1'b0, big.fr} + {1'b0, al};
    sum_o.sgn = big.sgn;
    sum_o.ex  = big.ex;
    sum_o.fr  = raw[FR_W-1:0];
    if (raw[FR_W]) begin
      sum_o.fr = FR_W'(raw >> DIG_W) & keep_mask;
      sum_o.ex = big.ex + SE_W'(1);
    end
    if (x_zero)      sum_o = y_i;
    else if (y_zero) sum_o = x_i;
  end
endmodule

// File: rtl/hfa_norm_step.sv
module hfa_norm_step
  import hfa_pkg::*;
(
  input  ufp_t v_i,
  output ufp_t v_o,
  output logic shift_o
);
  always_comb begin
    shift_o = (v_i.fr != '0) && (v_i.fr[FR_W-1 -: DIG_W] == '0);
    v_o     = v_i;
    if (shift_o) begin
      v_o.fr = v_i.fr << DIG_W;
      v_o.ex = v_i.ex - SE_W'(1);
    end
  end
endmodule

// File: rtl/hfa_pack.sv
module hfa_pack
  import hfa_pkg::*;
(
  input  ufp_t              v_i,
  input  logic              rnd_i,
  output logic [WORD_W-1:0] hi_o,
  output logic [LO_W-1:0]   lo_o,
  output logic              cc_v_o,
  output logic              cc_g_o,
  output logic              cc_l_o
);
  logic [HI_W:0]   hfr;
  logic [LO_W-1:0] lfr;
  logic [SE_W-1:0] ex;

  always_comb begin
    hfr = {1'b0, v_i.fr[FR_W-1:LO_W]};
    lfr = v_i.fr[LO_W-1:0];
    ex  = v_i.ex;
    if (rnd_i && lfr[LO_W-1]) begin
      hfr = hfr + (HI_W+1)'(1);
      if (hfr[HI_W]) begin
        hfr = hfr >> DIG_W;
        ex  = ex + SE_W'(1);
      end
    end
    hi_o   = '0;
    lo_o   = '0;
    cc_v_o = 1'b0;
    cc_g_o = 1'b0;
    cc_l_o = 1'b0;
    if (hfr == '0) begin
      cc_v_o = 1'b0;
    end else if ($signed(ex) < 0) begin
      cc_v_o = 1'b1;
    end else if ($signed(ex) > $signed(SE_W'(EXP_MAX))) begin
      hi_o   = {v_i.sgn, {(WORD_W-1){1'b1}}};
      lo_o   = '1;
      cc_v_o = 1'b1;
      cc_l_o = v_i.sgn;
      cc_g_o = ~v_i.sgn;
    end else begin
      hi_o   = {v_i.sgn, ex[EXP_W-1:0], hfr[HI_W-1:0]};
      lo_o   = lfr;
      cc_l_o = v_i.sgn;
      cc_g_o = ~v_i.sgn;
    end
  end
endmodule

// File: rtl/hfa_addsub.sv
module hfa_addsub
  import hfa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sub,
  input  logic              wide,
  input  logic              rnd_en,
  input  logic [WORD_W-1:0] a_hi,
  input  logic [LO_W-1:0]   a_lo,
  input  logic [WORD_W-1:0] b_hi,
  input  logic [LO_W-1:0]   b_lo,
  output logic [WORD_W-1:0] res_hi,
  output logic [LO_W-1:0]   res_lo,
  output logic              cc_v,
  output logic              cc_g,
  output logic              cc_l,
  output logic              done
);
  function automatic ufp_t unpack(input logic [WORD_W-1:0] hw,
                                  input logic [LO_W-1:0]   lw,
                                  input logic              use_lo,
                                  input logic              flip);
    ufp_t u;
    u.sgn = hw[WORD_W-1] ^ flip;
    u.ex  = SE_W'(hw[WORD_W-2:HI_W]);
    u.fr  = {hw[HI_W-1:0], (use_lo ? lw : {LO_W{1'b0}})};
    return u;
  endfunction

  // reset: asserted at once, released after two clock edges
  logic [1:0] rsync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_int_n = rsync[1];

  hfa_st_t           st, st_n;
  ufp_t              op_a, op_b, acc, acc_n, sum, nstep;
  logic              wide_q, rnd_q, need;
  logic              cap_en, acc_en, out_en;
  logic [WORD_W-1:0] pk_hi, res_hi_q;
  logic [LO_W-1:0]   pk_lo, res_lo_q;
  logic              pk_v, pk_g, pk_l, v_q, g_q, l_q, done_q;

  hfa_align u_align (
    .x_i    (op_a),
    .y_i    (op_b),
    .wide_i (wide_q),
    .sum_o  (sum)
  );

  hfa_norm_step u_norm (
    .v_i     (acc),
    .v_o     (nstep),
    .shift_o (need)
  );

  hfa_pack u_pack (
    .v_i    (acc),
    .rnd_i  (rnd_q),
    .hi_o   (pk_hi),
    .lo_o   (pk_lo),
    .cc_v_o (pk_v),
    .cc_g_o (pk_g),
    .cc_l_o (pk_l)
  );

  always_comb begin
    st_n   = st;
    cap_en = 1'b0;
    acc_en = 1'b0;
    out_en = 1'b0;
    acc_n  = sum;
    unique case (st)
      ST_IDLE:  if (start) begin
                  cap_en = 1'b1;
                  st_n   = ST_ALIGN;
                end
      ST_ALIGN: begin
                  acc_en = 1'b1;
                  acc_n  = sum;
                  st_n   = ST_NORM;
                end
      ST_NORM:  if (need) begin
                  acc_en = 1'b1;
                  acc_n  = nstep;
                end else begin
                  st_n = ST_FIN;
                end
      ST_FIN:   begin
                  out_en = 1'b1;
                  st_n   = ST_IDLE;
                end
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st       <= ST_IDLE;
      op_a     <= '0;
      op_b     <= '0;
      wide_q   <= 1'b0;
      rnd_q    <= 1'b0;
      acc      <= '0;
      res_hi_q <= '0;
      res_lo_q <= '0;
      v_q      <= 1'b0;
      g_q      <= 1'b0;
      l_q      <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st     <= st_n;
      done_q <= out_en;
      if (cap_en) begin
        op_a   <= unpack(a_hi, a_lo, wide, 1'b0);
        op_b   <= unpack(b_hi, b_lo, wide, sub);
        wide_q <= wide;
        rnd_q  <= rnd_en;
      end
      if (acc_en) acc <= acc_n;
      if (out_en) begin
        res_hi_q <= pk_hi;
        res_lo_q <= pk_lo;
        v_q      <= pk_v;
        g_q      <= pk_g;
        l_q      <= pk_l;
      end
    end
  end

  assign res_hi = res_hi_q;
  assign res_lo = res_lo_q;
  assign cc_v   = v_q;
  assign cc_g   = g_q;
  assign cc_l   = l_q;
  assign done   = done_q;

  // checker-side count of normalization steps in the current operation
  logic [CNT_W-1:0] norm_cnt;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)       norm_cnt <= '0;
    else if (st != ST_NORM) norm_cnt <= '0;
    else if (need)        norm_cnt <= norm_cnt + CNT_W'(1);
  end

  // R5
  norm_bound_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    norm_cnt <= CNT_W'(WIDE_CUT));

  // R5
  norm_out_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !cc_v && (cc_g || cc_l)) |-> (res_hi[HI_W-1 -: DIG_W] != '0));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st != ST_FIN) |=> ($stable(res_hi) && $stable(res_lo) && $stable(cc_v)));

  // R10
  ovf_fill_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && cc_v && (cc_g || cc_l)) |-> ((res_lo == '1) && (res_hi[WORD_W-2:0] == '1)));

  // R8
  zero_clean_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !cc_g && !cc_l) |-> ((res_hi == '0) && (res_lo == '0)));

  // R11
  cc_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !(cc_g && cc_l));

  // R11
  sign_cc_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && (cc_g || cc_l)) |-> (res_hi[WORD_W-1] == cc_l));
endmodule

// File: tb/sim_hfa_addsub.sv
module sim_hfa_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sub = 1'b0, wide = 1'b0, rnd_en = 1'b0;
  logic [31:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
  logic [31:0] res_hi, res_lo;
  logic        cc_v, cc_g, cc_l, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  hfa_addsub u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sub(sub), .wide(wide), .rnd_en(rnd_en),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .res_hi(res_hi), .res_lo(res_lo), .cc_v(cc_v), .cc_g(cc_g), .cc_l(cc_l), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // expected {hi, lo, v, g, l} computed from the requirements
  function automatic logic [66:0] model(input logic [31:0] ahi, input logic [31:0] alo,
                                        input logic [31:0] bhi, input logic [31:0] blo,
                                        input logic s, input logic w, input logic r);
    logic [63:0] fa, fb, fl, fs, f, h, msk;
    int          ea, eb, el, es, e, d, cut;
    logic        sa, sb, sl, ss, sg;
    logic [31:0] ohi, olo;
    logic        ov, og, ol;
    msk = 64'h00FF_FFFF_0000_0000;
    fa = {8'h00, ahi[23:0], (w ? alo : 32'h0)};
    fb = {8'h00, bhi[23:0], (w ? blo : 32'h0)};
    ea = int'(ahi[30:24]);
    eb = int'(bhi[30:24]);
    sa = ahi[31];
    sb = bhi[31] ^ s;
    if (fa == 0) begin
      sg = sb; e = eb; f = fb;
    end else if (fb == 0) begin
      sg = sa; e = ea; f = fa;
    end else begin
      if (ea > eb || (ea == eb && fa >= fb)) begin
        sl = sa; el = ea; fl = fa; ss = sb; es = eb; fs = fb;
      end else begin
        sl = sb; el = eb; fl = fb; ss = sa; es = ea; fs = fa;
      end
      d   = el - es;
      cut = w ? 14 : 6;
      if (d >= cut) fs = 0;
      else          fs = fs >> (4 * d);
      if (!w) fs = fs & msk;
      sg = sl;
      e  = el;
      if (sl != ss) begin
        f = fl - fs;
        while (f != 0 && f < 64'h0010_0000_0000_0000) begin
          f = f << 4;
          e = e - 1;
        end
      end else begin
        f = fl + fs;
        if (f >= 64'h0100_0000_0000_0000) begin
          f = f >> 4;
          e = e + 1;
          if (!w) f = f & msk;
        end
      end
    end
    h = {40'h0, f[55:32]};
    if (r && f[31]) begin
      h = h + 1;
      if (h >= 64'h0100_0000) begin
        h = h >> 4;
        e = e + 1;
      end
    end
    ohi = '0; olo = '0; ov = 0; og = 0; ol = 0;
    if (h == 0) begin
      ov = 0;
    end else if (e < 0) begin
      ov = 1;
    end else if (e > 127) begin
      ohi = {sg, 31'h7FFF_FFFF};
      olo = 32'hFFFF_FFFF;
      ov = 1; ol = sg; og = !sg;
    end else begin
      ohi = {sg, e[6:0], h[23:0]};
      olo = f[31:0];
      ol = sg; og = !sg;
    end
    return {ohi, olo, ov, og, ol};
  endfunction

  task automatic check(input string tag, input logic [31:0] ehi, input logic [31:0] elo,
                       input logic ev, input logic eg, input logic el);
    checks++;
    if (res_hi !== ehi || res_lo !== elo || cc_v !== ev || cc_g !== eg || cc_l !== el) begin
      errors++;
      $display("FAIL %s: actual=%h_%h vgl=%b%b%b expected=%h_%h vgl=%b%b%b",
               tag, res_hi, res_lo, cc_v, cc_g, cc_l, ehi, elo, ev, eg, el);
    end
  endtask

  task automatic run_op(input logic [31:0] ahi, input logic [31:0] alo,
                        input logic [31:0] bhi, input logic [31:0] blo,
                        input logic s, input logic w, input logic r);
    int n;
    @(negedge clk);
    a_hi = ahi; a_lo = alo; b_hi = bhi; b_lo = blo;
    sub = s; wide = w; rnd_en = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12: actual=no done expected=done pulse");
    end
  endtask

  task automatic op_model(input string tag, input logic [31:0] ahi, input logic [31:0] alo,
                          input logic [31:0] bhi, input logic [31:0] blo,
                          input logic s, input logic w, input logic r);
    logic [66:0] m;
    m = model(ahi, alo, bhi, blo, s, w, r);
    run_op(ahi, alo, bhi, blo, s, w, r);
    check(tag, m[66:35], m[34:3], m[2], m[1], m[0]);
  endtask

  function automatic logic [6:0] e_of(input int k);
    case (k % 8)
      0: return 7'h00;  1: return 7'h01;  2: return 7'h40;  3: return 7'h41;
      4: return 7'h45;  5: return 7'h4E;  6: return 7'h7E;  default: return 7'h7F;
    endcase
  endfunction

  function automatic logic [23:0] f_of(input int k);
    case (k % 8)
      0: return 24'h100000; 1: return 24'hFFFFFF; 2: return 24'h800000; 3: return 24'h123456;
      4: return 24'h100001; 5: return 24'hFFFFF0; 6: return 24'h000000; default: return 24'hA5A5A5;
    endcase
  endfunction

  function automatic logic [31:0] l_of(input int k);
    case (k % 8)
      0: return 32'h0000_0000; 1: return 32'hFFFF_FFFF; 2: return 32'h8000_0000; 3: return 32'h0000_0001;
      4: return 32'h7FFF_FFFF; 5: return 32'h1234_5678; 6: return 32'h0000_0000; default: return 32'hC000_0000;
    endcase
  endfunction

  initial begin
    logic [66:0] m;
    int          extra;
    repeat (3) @(negedge clk);
    // R12 reset state
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL R12: actual done=%b expected=0", done);
    end
    check("R12 reset", 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 subtract of equal values gives clean zero (R8)
    run_op(32'h4110_0000, 32'h0, 32'h4110_0000, 32'h0, 1, 1, 0);
    check("R1 R8", 32'h0, 32'h0, 0, 0, 0);
    // R3 larger magnitude sets sign: 1 - 16 = -15
    run_op(32'h4110_0000, 32'h0, 32'h4210_0000, 32'h0, 1, 0, 0);
    check("R3", 32'hC1F0_0000, 32'h0, 0, 0, 1);
    // R2 zero first operand with nonzero exponent, subtract
    run_op(32'h4500_0000, 32'h0, 32'h4230_0000, 32'h0, 1, 0, 0);
    check("R2 a zero", 32'hC230_0000, 32'h0, 0, 0, 1);
    run_op(32'hC230_0000, 32'h1234_5678, 32'h0000_0000, 32'h0, 0, 1, 0);
    check("R2 b zero", 32'hC230_0000, 32'h1234_5678, 0, 0, 1);
    // R6 carry renormalization, narrow
    run_op(32'h4180_0000, 32'h0, 32'h4180_0000, 32'h0, 0, 0, 0);
    check("R6", 32'h4210_0000, 32'h0, 0, 1, 0);
    // R4 narrow ignores low words
    run_op(32'h4110_0000, 32'hDEAD_BEEF, 32'h4110_0000, 32'h1234_5678, 0, 0, 1);
    check("R4 narrow low", 32'h4120_0000, 32'h0, 0, 1, 0);
    // R4 cutoffs
    run_op(32'h4610_0000, 32'h0, 32'h4010_0000, 32'h0, 0, 0, 0);
    check("R4 narrow cut", 32'h4610_0000, 32'h0, 0, 1, 0);
    run_op(32'h4610_0000, 32'h0, 32'h4010_0000, 32'h0, 0, 1, 0);
    check("R4 wide d6", 32'h4610_0000, 32'h1000_0000, 0, 1, 0);
    run_op(32'h4D10_0000, 32'h0, 32'h40F0_0000, 32'h0, 0, 1, 0);
    check("R4 wide d13", 32'h4D10_0000, 32'h0000_000F, 0, 1, 0);
    run_op(32'h4E10_0000, 32'h0, 32'h40F0_0000, 32'h0, 0, 1, 0);
    check("R4 wide cut", 32'h4E10_0000, 32'h0, 0, 1, 0);
    // R5 deep cancellation: 13 digit steps
    run_op(32'h4110_0000, 32'h0000_0001, 32'h4110_0000, 32'h0, 1, 1, 0);
    check("R5", 32'h3410_0000, 32'h0, 0, 1, 0);
    // R7 rounding
    run_op(32'h4110_0000, 32'h8000_0000, 32'h0, 32'h0, 0, 1, 1);
    check("R7", 32'h4110_0001, 32'h8000_0000, 0, 1, 0);
    run_op(32'h4110_0000, 32'h8000_0000, 32'h0, 32'h0, 0, 1, 0);
    check("R7 off", 32'h4110_0000, 32'h8000_0000, 0, 1, 0);
    // R7 with R10: rounding carry overflows the top exponent
    run_op(32'h7FFF_FFFF, 32'h8000_0000, 32'h0, 32'h0, 0, 1, 1);
    check("R7 R10", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0);
    // R9 underflow
    run_op(32'h0010_0001, 32'h0, 32'h0010_0000, 32'h0, 1, 0, 0);
    check("R9", 32'h0, 32'h0, 1, 0, 0);
    // R10 overflow, both signs
    run_op(32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0, 0, 0, 0);
    check("R10 neg", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 1);
    run_op(32'h7FFF_FFFF, 32'h0, 32'h7FFF_FFFF, 32'h0, 0, 1, 0);
    check("R10 pos", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0);

    // R12 start while busy is ignored, single done, outputs held
    @(negedge clk);
    a_hi = 32'h4130_0000; a_lo = 0; b_hi = 32'h4120_0000; b_lo = 0;
    sub = 0; wide = 0; rnd_en = 0; start = 1'b1;
    @(negedge clk);
    a_hi = 32'h4290_0000; b_hi = 32'hC110_0000; sub = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R12 busy", 32'h4150_0000, 32'h0, 0, 1, 0);
    extra = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    checks++;
    if (extra != 0) begin
      errors++;
      $display("FAIL R12: actual extra dones=%0d expected=0", extra);
    end
    check("R12 hold", 32'h4150_0000, 32'h0, 0, 1, 0);

    // sweep over control combinations and operand patterns (R4 R5 R6 R8-R11)
    for (int ctl = 0; ctl < 8; ctl++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          logic [31:0] ahi, alo, bhi, blo;
          string tag;
          ahi = {i[1], e_of(i), f_of(i * 5 + 1)};
          alo = (ahi[23:0] == 0) ? 32'h0 : l_of(i * 3);
          bhi = {i[0] ^ j[1], e_of(j), f_of(j * 5 + 1)};
          blo = (bhi[23:0] == 0) ? 32'h0 : l_of(j * 3 + (j >= 8 ? 1 : 0));
          m = model(ahi, alo, bhi, blo, ctl[0], ctl[1], ctl[2]);
          if (m[2] && (m[1] || m[0])) tag = "R10 sweep";
          else if (m[2])              tag = "R9 sweep";
          else if (!m[1] && !m[0])    tag = "R8 sweep";
          else                        tag = "R11 sweep";
          op_model(tag, ahi, alo, bhi, blo, ctl[0], ctl[1], ctl[2]);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule